// File: doc/BRIEF.md
# LPC I/O Cycle Target

This block sits on the peripheral side of a Low Pin Count bus and answers host I/O cycles. It watches a 4-bit multiplexed data bus and a frame strobe, both sampled on the rising edge of the bus clock. It recognises I/O read and I/O write cycles and compares the 16-bit I/O address with a small window of byte-wide registers held inside the block. Every other cycle type is ignored.

On a matched write it collects one data byte. On a matched read it drives the sync nibble, the two data nibbles and its own turnaround onto the bus in the right slots. The block never asks for wait states. A write becomes visible in the register array only when the final turnaround completes. Pulling the frame strobe low in the middle of a cycle abandons the cycle with no change to any register, and the target lets go of the bus at once.

Top module: `lpc_io_target`

## Requirements
- R1: After reset `bus_oe` is low and every register reads back as 8'h00.
- R2: A write cycle has the start nibble 0000 and the type nibble 0010. It then carries four address nibbles, the data low nibble, the data high nibble and two host turnaround slots. When its address lies in [ADDR_BASE, ADDR_BASE+REG_COUNT-1], the byte is stored in register (address - ADDR_BASE) as the cycle finishes, and a later read returns it.
- R3: A read cycle has the start nibble 0000 and the type nibble 0000. It then carries four address nibbles and two host turnaround slots. On a hit the target drives slots 9 to 12, counting the start slot as 1: sync 0000, the data bits 3-0, the data bits 7-4, then 1111. In slot 13 it releases the bus.
- R4: The address arrives most significant nibble first. An address outside the window never asserts `bus_oe`, and a write to it changes no register.
- R5: On a write hit the target drives sync 0000 in slot 11 and 1111 in slot 12. `bus_oe` is high in exactly those two slots.
- R6: A type nibble other than 0000 or 0010 is ignored. `bus_oe` stays low and no register changes.
- R7: The frame strobe sampled low while a cycle is in progress aborts that cycle. `bus_oe` is low from the next slot on, and no register changes. This holds even when the abort lands in the last turnaround slot.
- R8: The frame strobe low in idle starts a cycle only when the bus nibble is 0000. Any other value leaves the target idle.
- R9: The target is back in idle in the slot right after slot 13, so a new start can follow with no gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all sampling on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_n | input | 1 | Active-low cycle framing strobe |
| bus_in | input | 4 | Nibble currently on the multiplexed bus |
| bus_out | output | 4 | Nibble the target drives when enabled |
| bus_oe | output | 1 | Output enable for `bus_out` |

## Verification
A wrong sequencer state shows up at the bus within one slot. The output enable rises or falls one slot off, the sync nibble is missing, or the two data nibbles come back in the wrong order. A bad decode or a commit that fires early does not show up until a later read of the register, so every abort, miss and ignored-type cycle is followed by reads of the whole register window. The abort path is covered by aborting at every slot of a write cycle and at every driven slot of a read. Each abort must release the bus in the very next slot.

// File: rtl/lpc_tgt_pkg.sv
package lpc_tgt_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_TYPE  = 3'd1,
        ST_ADDR  = 3'd2,
        ST_WDATA = 3'd3,
        ST_HTAR  = 3'd4,
        ST_SYNC  = 3'd5,
        ST_RDATA = 3'd6,
        ST_TTAR  = 3'd7
    } lpc_state_e;

    localparam logic [3:0] NIB_START   = 4'h0;
    localparam logic [3:0] NIB_IO_RD   = 4'h0;
    localparam logic [3:0] NIB_IO_WR   = 4'h2;
    localparam logic [3:0] NIB_READY   = 4'h0;
    localparam logic [3:0] NIB_TAR     = 4'hF;

endpackage

// File: rtl/lpc_tgt_addr_dec.sv
module lpc_tgt_addr_dec #(
    parameter logic [15:0] ADDR_BASE = 16'h0CA0,
    parameter int          REG_COUNT = 4,
    localparam int         IDX_W     = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1
) (
    input  logic [15:0]      addr,
    output logic             hit,
    output logic [IDX_W-1:0] idx
);

    logic [REG_COUNT-1:0] hit_vec;

    for (genvar g = 0; g < REG_COUNT; g++) begin : g_cmp
        assign hit_vec[g] = (addr == 16'(ADDR_BASE + 16'(g)));
    end

    always_comb begin
        idx = '0;
        for (int i = 0; i < REG_COUNT; i++) begin
            if (hit_vec[i]) idx = IDX_W'(i);
        end
    end

    assign hit = |hit_vec;

endmodule

// File: rtl/lpc_tgt_seq.sv
module lpc_tgt_seq
    import lpc_tgt_pkg::*;
#(
    parameter int  IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_n,
    input  logic [3:0]       bus_in,
    input  logic             dec_hit,
    input  logic [IDX_W-1:0] dec_idx,
    output logic [15:0]      cand_addr,
    output lpc_state_e       state,
    output logic [1:0]       slot_cnt,
    output logic [IDX_W-1:0] sel_idx,
    output logic [7:0]       wr_byte,
    output logic             commit
);

    typedef struct packed {
        lpc_state_e       st;
        logic [1:0]       cnt;
        logic             wr;
        logic [11:0]      ahi;
        logic [IDX_W-1:0] idx;
        logic [7:0]       wdat;
    } seq_t;

    seq_t seq_d, seq_q;
    logic commit_d;

    assign cand_addr = {seq_q.ahi, bus_in};

    always_comb begin
        seq_d    = seq_q;
        commit_d = 1'b0;
        if (seq_q.st != ST_IDLE && !frame_n) begin
            // abort: drop everything in flight
            seq_d.st  = ST_IDLE;
            seq_d.cnt = '0;
        end else begin
            unique case (seq_q.st)
                ST_IDLE: begin
                    seq_d.cnt = '0;
                    if (!frame_n && bus_in == NIB_START) seq_d.st = ST_TYPE;
                end
                ST_TYPE: begin
                    seq_d.cnt = '0;
                    if (bus_in == NIB_IO_RD) begin
                        seq_d.wr = 1'b0;
                        seq_d.st = ST_ADDR;
                    end else if (bus_in == NIB_IO_WR) begin
                        seq_d.wr = 1'b1;
                        seq_d.st = ST_ADDR;
                    end else begin
                        seq_d.st = ST_IDLE;
                    end
                end
                ST_ADDR: begin
                    seq_d.ahi = {seq_q.ahi[7:0], bus_in};
                    seq_d.cnt = seq_q.cnt + 2'd1;
                    if (seq_q.cnt == 2'd3) begin
                        seq_d.cnt = '0;
                        if (dec_hit) begin
                            seq_d.idx = dec_idx;
                            seq_d.st  = seq_q.wr ? ST_WDATA : ST_HTAR;
                        end else begin
                            seq_d.st  = ST_IDLE;
                        end
                    end
                end
                ST_WDATA: begin
                    if (seq_q.cnt == 2'd0) begin
                        seq_d.wdat[3:0] = bus_in;
                        seq_d.cnt       = 2'd1;
                    end else begin
                        seq_d.wdat[7:4] = bus_in;
                        seq_d.cnt       = '0;
                        seq_d.st        = ST_HTAR;
                    end
                end
                ST_HTAR: begin
                    if (seq_q.cnt == 2'd0) begin
                        seq_d.cnt = 2'd1;
                    end else begin
                        seq_d.cnt = '0;
                        seq_d.st  = ST_SYNC;
                    end
                end
                ST_SYNC: begin
                    seq_d.cnt = '0;
                    seq_d.st  = seq_q.wr ? ST_TTAR : ST_RDATA;
                end
                ST_RDATA: begin
                    if (seq_q.cnt == 2'd0) begin
                        seq_d.cnt = 2'd1;
                    end else begin
                        seq_d.cnt = '0;
                        seq_d.st  = ST_TTAR;
                    end
                end
                ST_TTAR: begin
                    if (seq_q.cnt == 2'd0) begin
                        seq_d.cnt = 2'd1;
                    end else begin
                        seq_d.cnt = '0;
                        seq_d.st  = ST_IDLE;
                        commit_d  = seq_q.wr;
                    end
                end
                default: seq_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '0;
        else        seq_q <= seq_d;
    end

    assign state    = seq_q.st;
    assign slot_cnt = seq_q.cnt;
    assign sel_idx  = seq_q.idx;
    assign wr_byte  = seq_q.wdat;
    assign commit   = commit_d;

endmodule

// File: rtl/lpc_tgt_regfile.sv
module lpc_tgt_regfile #(
    parameter int  REG_COUNT = 4,
    localparam int IDX_W     = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             idx,
    input  logic [7:0]                   wr_byte,
    output logic [7:0]                   rd_byte,
    output logic [REG_COUNT-1:0][7:0]    image
);

    logic [REG_COUNT-1:0][7:0] regs_d, regs_q;

    for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
        always_comb begin
            regs_d[g] = regs_q[g];
            if (wr_en && idx == IDX_W'(g)) regs_d[g] = wr_byte;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) regs_q[g] <= '0;
            else        regs_q[g] <= regs_d[g];
        end
    end

    always_comb begin
        rd_byte = '0;
        for (int i = 0; i < REG_COUNT; i++) begin
            if (idx == IDX_W'(i)) rd_byte = regs_q[i];
        end
    end

    assign image = regs_q;

endmodule

// File: rtl/lpc_io_target.sv
module lpc_io_target
    import lpc_tgt_pkg::*;
#(
    parameter logic [15:0] ADDR_BASE = 16'h0CA0,
    parameter int          REG_COUNT = 4,
    localparam int         IDX_W     = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_n,
    input  logic [3:0] bus_in,
    output logic [3:0] bus_out,
    output logic       bus_oe
);

    logic [15:0]               cand_addr;
    logic                      dec_hit;
    logic [IDX_W-1:0]          dec_idx;
    lpc_state_e                state;
    logic [1:0]                slot_cnt;
    logic [IDX_W-1:0]          sel_idx;
    logic [7:0]                wr_byte;
    logic [7:0]                rd_byte;
    logic                      commit;
    logic [REG_COUNT-1:0][7:0] reg_image;

    lpc_tgt_addr_dec #(
        .ADDR_BASE (ADDR_BASE),
        .REG_COUNT (REG_COUNT)
    ) u_dec (
        .addr (cand_addr),
        .hit  (dec_hit),
        .idx  (dec_idx)
    );

    lpc_tgt_seq #(
        .IDX_W (IDX_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .frame_n   (frame_n),
        .bus_in    (bus_in),
        .dec_hit   (dec_hit),
        .dec_idx   (dec_idx),
        .cand_addr (cand_addr),
        .state     (state),
        .slot_cnt  (slot_cnt),
        .sel_idx   (sel_idx),
        .wr_byte   (wr_byte),
        .commit    (commit)
    );

    lpc_tgt_regfile #(
        .REG_COUNT (REG_COUNT)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (commit),
        .idx     (sel_idx),
        .wr_byte (wr_byte),
        .rd_byte (rd_byte),
        .image   (reg_image)
    );

    // Target-driven slots decoded straight from the sequencer state.
    always_comb begin
        bus_oe  = 1'b0;
        bus_out = NIB_TAR;
        unique case (state)
            ST_SYNC: begin
                bus_oe  = 1'b1;
                bus_out = NIB_READY;
            end
            ST_RDATA: begin
                bus_oe  = 1'b1;
                bus_out = (slot_cnt == 2'd0) ? rd_byte[3:0] : rd_byte[7:4];
            end
            ST_TTAR: begin
                bus_oe  = (slot_cnt == 2'd0);
                bus_out = NIB_TAR;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/lpc_io_target_chk.sv
module lpc_io_target_chk #(
    parameter int REG_COUNT = 4
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      frame_n,
    input logic                      bus_oe,
    input logic [3:0]                bus_out,
    input logic                      commit,
    input logic [REG_COUNT-1:0][7:0] reg_image
);

    logic [2:0] oe_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            oe_run <= '0;
        else if (!bus_oe)      oe_run <= '0;
        else if (oe_run != 3'd7) oe_run <= oe_run + 3'd1;
    end

    // R7: frame low seen on an edge leaves the bus released after it
    assert_abort_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_n |=> !bus_oe);

    // R3: the first driven nibble of any response is the ready sync
    assert_sync_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_oe) |-> bus_out == 4'h0);

    // R3: a response never holds the bus longer than four slots
    assert_oe_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> oe_run < 3'd4);

    // R5: a normal release is preceded by the 1111 turnaround nibble
    assert_tar_before_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(bus_oe) && $past(frame_n)) |-> $past(bus_out) == 4'hF);

    // R7: registers move only on the edge that completes a write
    assert_regs_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(reg_image));

endmodule

bind lpc_io_target lpc_io_target_chk #(.REG_COUNT(REG_COUNT)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .frame_n   (frame_n),
    .bus_oe    (bus_oe),
    .bus_out   (bus_out),
    .commit    (commit),
    .reg_image (reg_image)
);

// File: tb/lpc_io_target_test.sv
module lpc_io_target_test;

    localparam logic [15:0] BASE = 16'h0CA0;
    localparam int          N    = 4;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       frame_n;
    logic [3:0] bus_in;
    logic [3:0] bus_out;
    logic       bus_oe;

    always #5 clk = ~clk;

    lpc_io_target #(.ADDR_BASE(BASE), .REG_COUNT(N)) uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .frame_n (frame_n),
        .bus_in  (bus_in),
        .bus_out (bus_out),
        .bus_oe  (bus_oe)
    );

    int   n_checks = 0;
    int   n_fails  = 0;
    bit   done     = 1'b0;
    logic [7:0]  model [N];
    logic [15:0] oe_seen;
    logic [3:0]  out_seen [16];

    task automatic check_eq(input string req, input string what,
                            input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic slot(input logic fr, input logic [3:0] nib, input int k);
        @(negedge clk);
        oe_seen[k]  = bus_oe;
        out_seen[k] = bus_out;
        frame_n     = fr;
        bus_in      = nib;
    endtask

    function automatic logic [3:0] nib_for(input logic [3:0] typ, input logic [15:0] a,
                                           input logic [7:0] wd, input int k);
        case (k)
            1: return 4'h0;
            2: return typ;
            3: return a[15:12];
            4: return a[11:8];
            5: return a[7:4];
            6: return a[3:0];
            7: return (typ == 4'h0) ? 4'hF : wd[3:0];
            8: return (typ == 4'h0) ? 4'hF : wd[7:4];
            default: return 4'hF;
        endcase
    endfunction

    // abort_at = 0 runs all 13 slots; otherwise frame goes low in that slot
    task automatic run_cycle(input logic [3:0] typ, input logic [15:0] a,
                             input logic [7:0] wd, input int abort_at);
        oe_seen = '0;
        for (int k = 1; k <= 13; k++) begin
            if (k == abort_at) begin
                slot(1'b0, 4'hF, k);
                slot(1'b1, 4'hF, k + 1);
                return;
            end
            slot(k != 1, nib_for(typ, a, wd, k), k);
        end
    endtask

    task automatic do_read(input string req, input logic [15:0] a,
                           input bit hit, input logic [7:0] exp);
        run_cycle(4'h0, a, 8'h00, 0);
        check_eq(req, "read oe slots", oe_seen, hit ? 16'h1E00 : 16'h0000);
        if (hit) begin
            check_eq(req, "read sync", {12'h0, out_seen[9]}, 16'h0);
            check_eq(req, "read data", {8'h0, out_seen[11], out_seen[10]}, {8'h0, exp});
            check_eq(req, "read tar", {12'h0, out_seen[12]}, 16'hF);
        end
    endtask

    task automatic do_write(input string req, input logic [15:0] a,
                            input bit hit, input logic [7:0] wd);
        run_cycle(4'h2, a, wd, 0);
        check_eq(req, "write oe slots", oe_seen, hit ? 16'h1800 : 16'h0000);
        if (hit) begin
            check_eq("R5", "write sync", {12'h0, out_seen[11]}, 16'h0);
            check_eq("R5", "write tar", {12'h0, out_seen[12]}, 16'hF);
            model[int'(a - BASE)] = wd;
        end
    endtask

    task automatic read_all(input string req);
        for (int i = 0; i < N; i++) do_read(req, 16'(BASE + 16'(i)), 1'b1, model[i]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [7:0] pats [4];
        logic [15:0] misses [5];
        pats[0] = 8'h00; pats[1] = 8'hFF; pats[2] = 8'hA5; pats[3] = 8'h3C;
        misses[0] = BASE - 16'd1;
        misses[1] = BASE + 16'(N);
        misses[2] = {BASE[3:0], BASE[7:4], BASE[11:8], BASE[15:12]};
        misses[3] = BASE ^ 16'h8000;
        misses[4] = BASE ^ 16'h0100;
        for (int i = 0; i < N; i++) model[i] = 8'h00;

        rst_n = 1'b0; frame_n = 1'b1; bus_in = 4'hF;
        repeat (3) @(negedge clk);
        check_eq("R1", "oe in reset", {15'h0, bus_oe}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1", "oe after reset", {15'h0, bus_oe}, 16'h0);
        read_all("R1");

        // R2/R3 sweep: every register, several data patterns, write then read (R9 back-to-back)
        for (int i = 0; i < N; i++) begin
            for (int p = 0; p < 4; p++) begin
                do_write("R2", 16'(BASE + 16'(i)), 1'b1, pats[p] ^ 8'(i * 17));
                do_read("R9", 16'(BASE + 16'(i)), 1'b1, model[i]);
            end
        end
        for (int i = 0; i < N; i++) do_write("R2", 16'(BASE + 16'(i)), 1'b1, 8'(8'h11 * (i + 3)));
        read_all("R2");

        // R4: addresses just outside the window and with nibbles reordered
        for (int m = 0; m < 5; m++) begin
            do_write("R4", misses[m], 1'b0, 8'hEE);
            do_read("R4", misses[m], 1'b0, 8'h00);
        end
        read_all("R4");

        // R6: every unsupported cycle type
        for (int t = 0; t < 16; t++) begin
            if (t != 0 && t != 2) begin
                run_cycle(4'(t), 16'(BASE + 16'd1), 8'h99, 0);
                check_eq("R6", "ignored type oe", oe_seen, 16'h0);
            end
        end
        read_all("R6");

        // R8: frame low in idle with a non-start nibble, then a full write pattern
        for (int s = 1; s < 16; s++) begin
            oe_seen = '0;
            slot(1'b0, 4'(s), 1);
            for (int k = 2; k <= 13; k++) slot(1'b1, nib_for(4'h2, 16'(BASE + 16'd2), 8'h77, k), k);
            check_eq("R8", "bad start oe", oe_seen, 16'h0);
        end
        read_all("R8");

        // R7: abort a write at every slot, and a read at each driven slot
        for (int a = 2; a <= 13; a++) begin
            run_cycle(4'h2, 16'(BASE + 16'd2), 8'(8'hC3 ^ 8'(a)), a);
            check_eq("R7", "oe after write abort", {15'h0, oe_seen[a + 1]}, 16'h0);
            do_read("R7", 16'(BASE + 16'd2), 1'b1, model[2]);
        end
        for (int a = 9; a <= 12; a++) begin
            run_cycle(4'h0, 16'(BASE + 16'd1), 8'h00, a);
            check_eq("R7", "oe in aborted read slot", {15'h0, oe_seen[a]}, 16'h1);
            check_eq("R7", "oe after read abort", {15'h0, oe_seen[a + 1]}, 16'h0);
        end
        read_all("R7");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule